// File: doc/BRIEF.md
# CCD Vertical Charge Sweep Pulse Generator

This block drives the vertical transfer phases of an interline area sensor with a fast pulse burst. The burst clears unwanted charge out of the vertical registers before a full-resolution readout. A one-clock start request arms the generator. The burst begins at the next line-start strobe and continues over as many lines as it needs, including across a frame wrap. It stops on the exact transfer stage that reaches the selected count, even when that stage ends in the middle of a line. A one-clock completion flag then marks the end of the burst.

Two waveforms drive the four vertical phase groups. Groups 1 and 3 toggle every 40 pixel clocks, starting at clock offset 2 of each line. Groups 2 and 4 toggle on the same 40-clock grid, but 20 clocks later. The result is an interleaved two-group square wave in which neighbouring phases overlap. One transfer stage is a full cycle of both waveforms. A select input, latched with the start request, chooses between a long sweep and a short sweep. Level shifting to the sensor's drive voltages is done outside this block.

Top module: `ccd_sweep_gen`

## Requirements
- R1: While reset is applied, and after it until a sweep starts, `vphase` is 0 and `sweep_done` is 0.
- R2: A start request that the block accepts in some clock has no visible effect until the first `line_start` strictly after that clock. That strobe marks offset 0 of the first sweep line. Without a start request, no pulses are produced.
- R3: The group 1/3 waveform begins low and toggles in every clock whose line offset is 2 + 40·k and lies below 2280. The change shows on the edge that ends that clock. The last toggle of a line is at offset 2242, and the pattern resumes at offset 2 of the next line.
- R4: The group 2/4 waveform begins low and toggles at offsets 22 + 40·k, with the last toggle of a line at offset 2262. It uses the same timing convention as R3.
- R5: `vphase` bit 0 (group 1) and bit 2 (group 3) always carry the group 1/3 waveform. Bit 1 (group 2) and bit 3 (group 4) always carry the group 2/4 waveform.
- R6: Before each fall of the group 1/3 waveform, both waveforms have been high together for at least 20 clocks. Group 2/4 rises only while group 1/3 is high, and group 1/3 falls only while group 2/4 is high.
- R7: One stage is the sequence: 1/3 rises, 2/4 rises, 1/3 falls, 2/4 falls. `short_sweep` is sampled with an accepted start request. Value 0 selects 1368 stages and value 1 selects 684 stages.
- R8: The sweep ends on the 2/4 fall that completes the final stage, whether or not that fall is at the end of a line. After that, all four phases stay low and later line strobes start nothing.
- R9: `sweep_done` is high for exactly one clock, in the same clock in which the final 2/4 fall becomes visible.
- R10: A start request made while a sweep is armed or running is ignored, together with its `short_sweep` value. The stage count, timing and completion of that sweep do not change.
- R11: Once a sweep has completed, a new start request is accepted and behaves as described in R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-clock strobe marking offset 0 of a line |
| sweep_go | input | 1 | One-clock start request |
| short_sweep | input | 1 | Stage-count select (0 long, 1 short), sampled with the start request |
| vphase | output | 4 | Phase enables; bit g drives vertical group g+1 |
| sweep_done | output | 1 | One-clock completion flag |

## Verification
Start requests are placed at three kinds of points: one clock before a line strobe, which gives the shortest wait; in the same clock as a strobe, which must wait a whole line; and at random points. Each placement shows whether the first sweep line is chosen correctly. Long and short sweeps are mixed, and with the bench line length both end in the middle of a line. This separates a correct mid-line stop from one that stops at a line boundary, and it exposes an off-by-one in the stage count. Extra start requests, carrying the opposite select value, are sent both while the block is armed and while it is running. A block that wrongly accepts them produces a different stage count or a second completion pulse. Every cycle of every sweep is compared against an edge-count model, so a wrong offset, a wrong line wrap or a wrong overlap shows up in the exact cycle where it happens.

// File: rtl/ccd_sweep_pkg.sv
package ccd_sweep_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_ARMED = 2'd1,
    SW_RUN   = 2'd2
  } sweep_state_e;

  // number of stages for the selected sweep length
  function automatic int unsigned stage_target(input logic short_sel,
                                               input int unsigned long_n,
                                               input int unsigned short_n);
    return short_sel ? short_n : long_n;
  endfunction

  // clocks during which both waveforms are high within one period
  function automatic int unsigned overlap_clks(input int unsigned step,
                                               input int unsigned a_off,
                                               input int unsigned b_off);
    return step - (b_off - a_off);
  endfunction

endpackage

// File: rtl/sweep_line_timer.sv
module sweep_line_timer #(
  parameter int unsigned LINE_CLKS = 2280,
  parameter int unsigned STEP_CLKS = 40,
  parameter int unsigned A_OFF     = 2,
  parameter int unsigned B_OFF     = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  output logic a_hit,
  output logic b_hit
);
  localparam int unsigned PW = $clog2(LINE_CLKS + 1);
  localparam int unsigned SW = $clog2(STEP_CLKS);
  localparam logic [PW-1:0] LINE_MAX = PW'(LINE_CLKS);
  localparam logic [SW-1:0] SUB_MAX  = SW'(STEP_CLKS - 1);
  localparam logic [SW-1:0] A_SLOT   = SW'(A_OFF);
  localparam logic [SW-1:0] B_SLOT   = SW'(B_OFF);

  logic [PW-1:0] pos_q, pos_now;
  logic [SW-1:0] sub_q, sub_now;
  logic          in_line;

  // offset of the current clock inside the line; parks past the end
  always_comb begin
    if (line_start) begin
      pos_now = '0;
      sub_now = '0;
    end else begin
      pos_now = (pos_q == LINE_MAX) ? pos_q : pos_q + 1'b1;
      sub_now = (sub_q == SUB_MAX) ? '0 : sub_q + 1'b1;
    end
  end

  assign in_line = (pos_now != LINE_MAX);
  assign a_hit   = in_line && (sub_now == A_SLOT);
  assign b_hit   = in_line && (sub_now == B_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= LINE_MAX;
      sub_q <= '0;
    end else begin
      pos_q <= pos_now;
      sub_q <= sub_now;
    end
  end

  // R3
  a_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_hit |-> (pos_now < LINE_MAX) && !b_hit);

endmodule

// File: rtl/sweep_phase_gen.sv
module sweep_phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic a_hit,
  input  logic b_hit,
  output logic phase_a,
  output logic phase_b,
  output logic stage_end
);
  // a stage closes when the group 2/4 waveform falls
  assign stage_end = run && b_hit && phase_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_a <= 1'b0;
      phase_b <= 1'b0;
    end else if (!run) begin
      phase_a <= 1'b0;
      phase_b <= 1'b0;
    end else begin
      if (a_hit) phase_a <= ~phase_a;
      if (b_hit) phase_b <= ~phase_b;
    end
  end

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!phase_a && !phase_b));

  // R6
  b_rise_inside_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && b_hit && !phase_b) |-> phase_a);

endmodule

// File: rtl/sweep_stage_ctrl.sv
module sweep_stage_ctrl
  import ccd_sweep_pkg::*;
#(
  parameter int unsigned LONG_STAGES  = 1368,
  parameter int unsigned SHORT_STAGES = 684
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic go,
  input  logic short_sel,
  input  logic stage_end,
  output logic run,
  output logic done
);
  localparam int unsigned MAX_N = (LONG_STAGES > SHORT_STAGES) ? LONG_STAGES : SHORT_STAGES;
  localparam int unsigned CW    = $clog2(MAX_N + 1);

  sweep_state_e  st_q;
  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt;
  logic          last_stage;
  logic          done_q;

  assign tgt        = CW'(stage_target(sel_q, LONG_STAGES, SHORT_STAGES));
  assign last_stage = (cnt_q == tgt - CW'(1));
  assign run        = (st_q == SW_RUN);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SW_IDLE: if (go) begin
          st_q  <= SW_ARMED;
          sel_q <= short_sel;
        end
        SW_ARMED: if (line_start) begin
          st_q  <= SW_RUN;
          cnt_q <= '0;
        end
        SW_RUN: if (stage_end) begin
          if (last_stage) begin
            st_q   <= SW_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < tgt));

  // R8
  stop_at_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stage_end && last_stage) |=> (!run && done_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SW_IDLE && go) |=> $stable(sel_q));

endmodule

// File: rtl/ccd_sweep_gen.sv
module ccd_sweep_gen
  import ccd_sweep_pkg::*;
#(
  parameter int unsigned LINE_CLKS    = 2280,
  parameter int unsigned STEP_CLKS    = 40,
  parameter int unsigned A_OFF        = 2,
  parameter int unsigned B_OFF        = 22,
  parameter int unsigned LONG_STAGES  = 1368,
  parameter int unsigned SHORT_STAGES = 684,
  parameter int unsigned MIN_OVERLAP  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       sweep_go,
  input  logic       short_sweep,
  output logic [3:0] vphase,
  output logic       sweep_done
);
  localparam int unsigned OW        = $clog2(STEP_CLKS + 1);
  localparam int unsigned NOM_OVL   = overlap_clks(STEP_CLKS, A_OFF, B_OFF);
  localparam logic [OW-1:0] OVL_SAT = OW'(STEP_CLKS);

  logic a_hit, b_hit;
  logic run, stage_end;
  logic phase_a, phase_b;

  sweep_line_timer #(
    .LINE_CLKS(LINE_CLKS), .STEP_CLKS(STEP_CLKS), .A_OFF(A_OFF), .B_OFF(B_OFF)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .a_hit(a_hit), .b_hit(b_hit)
  );

  sweep_stage_ctrl #(
    .LONG_STAGES(LONG_STAGES), .SHORT_STAGES(SHORT_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .go(sweep_go),
    .short_sel(short_sweep), .stage_end(stage_end),
    .run(run), .done(sweep_done)
  );

  sweep_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .a_hit(a_hit), .b_hit(b_hit),
    .phase_a(phase_a), .phase_b(phase_b), .stage_end(stage_end)
  );

  // even groups follow waveform A, odd groups waveform B
  for (genvar g = 0; g < 4; g++) begin : g_map
    if (g % 2 == 0) begin : g_a
      assign vphase[g] = phase_a;
    end else begin : g_b
      assign vphase[g] = phase_b;
    end
  end

  // run length of the both-high window, for the overlap rule
  logic [OW-1:0] ovl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovl_q <= '0;
    else if (phase_a && phase_b) ovl_q <= (ovl_q == OVL_SAT) ? ovl_q : ovl_q + 1'b1;
    else                        ovl_q <= '0;
  end

  // R6
  min_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_a) |-> (ovl_q >= OW'(MIN_OVERLAP)) && (NOM_OVL >= MIN_OVERLAP));

  // R6
  a_fall_inside_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_a) |-> phase_b);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (vphase == 4'b0000) && $fell(phase_b));

endmodule

// File: tb/ccd_sweep_gen_tb.sv
module ccd_sweep_gen_tb;
  localparam int LINE = 280, STEP = 40, AOFF = 2, BOFF = 22;
  localparam int NLONG = 24, NSHORT = 12, MINOV = 20;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, sweep_go = 1'b0, short_sweep = 1'b0;
  logic [3:0] vphase;
  logic       sweep_done;
  int tests = 0, fails = 0, cyc = 0, cur = 0;
  logic [3:0] vs;
  logic       ds;

  always #4 clk = ~clk;

  ccd_sweep_gen #(
    .LINE_CLKS(LINE), .STEP_CLKS(STEP), .A_OFF(AOFF), .B_OFF(BOFF),
    .LONG_STAGES(NLONG), .SHORT_STAGES(NSHORT), .MIN_OVERLAP(MINOV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .sweep_go(sweep_go),
    .short_sweep(short_sweep), .vphase(vphase), .sweep_done(sweep_done)
  );

  // toggle slots per line for a waveform starting at offset off
  function automatic int per_line(int off);
    return (LINE - 1 - off) / STEP + 1;
  endfunction

  // toggles of a waveform at or before clock t of the sweep (t=0 is the first strobe)
  function automatic int edges_upto(int t, int off);
    int q, n, k;
    if (t < 0) return 0;
    q = t % LINE;
    n = (t / LINE) * per_line(off);
    if (q >= off) begin
      k = (q - off) / STEP + 1;
      n += (k < per_line(off)) ? k : per_line(off);
    end
    return n;
  endfunction

  function automatic bit level(int t, int off, int n);
    int k;
    k = edges_upto(t, off);
    if (k > 2 * n) k = 2 * n;
    return k[0];
  endfunction

  function automatic bit done_at(int t, int n);
    return (edges_upto(t, BOFF) >= 2 * n) && (edges_upto(t - 1, BOFF) < 2 * n);
  endfunction

  task automatic tick(input bit go, input bit sel);
    line_start  = (cyc % LINE == 0);
    sweep_go    = go;
    short_sweep = sel;
    @(negedge clk);
    vs  = vphase;
    ds  = sweep_done;
    cur = cyc;
    cyc++;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cur);
    end
  endtask

  task automatic sweep(input bit sel, input int mode, input bit extra);
    int n, tg, l0, k, dc, x1, x2, t;
    int e_pre, e_a, e_b, e_m, e_d, e_tail, a_act, a_exp, b_act, b_exp, d_act, d_exp;
    int rises, run_both, min_run, dones;
    bit pa;
    repeat ($urandom_range(40, 5)) tick(1'b0, 1'b0);
    if (mode == 1) while (cyc % LINE != LINE - 1) tick(1'b0, 1'b0);
    if (mode == 2) while (cyc % LINE != 0) tick(1'b0, 1'b0);
    n  = sel ? NSHORT : NLONG;
    tg = cyc;
    l0 = (tg / LINE + 1) * LINE;
    k  = 2 * n - 1;
    dc = l0 + (k / per_line(BOFF)) * LINE + BOFF + (k % per_line(BOFF)) * STEP;
    x1 = -1; x2 = -1;
    if (extra) begin
      if (l0 - tg > 1) x1 = tg + 1 + int'($urandom_range(l0 - tg - 2));
      x2 = l0 + 1 + int'($urandom_range(dc - l0 - 2));
    end
    e_pre = 0; e_a = 0; e_b = 0; e_m = 0; e_d = 0; e_tail = 0;
    a_act = 0; a_exp = 0; b_act = 0; b_exp = 0; d_act = 0; d_exp = 0;
    rises = 0; run_both = 0; min_run = 1000; dones = 0; pa = 1'b0;
    for (int c = tg; c <= dc + LINE + 5; c++) begin
      bit g, ea, eb, ed;
      g = (c == tg) || (c == x1) || (c == x2);
      tick(g, (c == tg) ? sel : ~sel);
      t  = c - l0;
      ea = level(t, AOFF, n);
      eb = level(t, BOFF, n);
      ed = done_at(t, n);
      if (c < l0 && (vs != 4'b0 || ds)) e_pre++;
      if (c > dc && (vs != 4'b0 || ds)) e_tail++;
      if (vs[0] != ea) begin if (e_a == 0) begin a_act = vs[0]; a_exp = ea; end e_a++; end
      if (vs[1] != eb) begin if (e_b == 0) begin b_act = vs[1]; b_exp = eb; end e_b++; end
      if (vs[2] != vs[0] || vs[3] != vs[1]) e_m++;
      if (ds != ed) begin if (e_d == 0) begin d_act = ds; d_exp = ed; end e_d++; end
      if (ds) dones++;
      if (vs[0] && !pa) rises++;
      if (!vs[0] && pa && run_both < min_run) min_run = run_both;
      run_both = (vs[0] && vs[1]) ? run_both + 1 : 0;
      pa = vs[0];
    end
    // R2 (and R11 for every sweep after the first)
    check(e_pre == 0, "R2", "activity before first strobe", e_pre, 0);
    check(e_a == 0, "R3", "group1/3 level", a_act, a_exp);
    check(e_b == 0, "R4", "group2/4 level", b_act, b_exp);
    check(e_m == 0, "R5", "mirrored group mismatches", e_m, 0);
    check(min_run >= MINOV, "R6", "shortest overlap", min_run, MINOV);
    check(rises == n, "R7", "stages emitted", rises, n);
    check(e_tail == 0, "R8", "activity after final stage", e_tail, 0);
    check(e_d == 0, "R9", "done level", d_act, d_exp);
    if (extra) check(dones == 1 && e_a == 0, "R10", "done pulses with ignored requests", dones, 1);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    // R1: reset state
    for (int i = 0; i < 6; i++) begin
      tick(1'b0, 1'b0);
      check(vs == 4'b0 && !ds, "R1", "outputs in reset", {27'd0, ds, vs}, 0);
    end
    rst_n = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 2 * LINE; i++) begin
        tick(1'b0, 1'b0);
        if (vs != 4'b0 || ds) bad++;
      end
      check(bad == 0, "R1", "outputs idle without request", bad, 0);
      check(bad == 0, "R2", "no sweep without request", bad, 0);
    end
    sweep(1'b1, 1, 1'b0);   // request one clock before a strobe
    sweep(1'b0, 2, 1'b0);   // request on a strobe: waits a full line
    sweep(1'b1, 0, 1'b1);   // R10 ignored requests while armed and running
    for (int s = 0; s < 5; s++) begin
      sweep(1'($urandom_range(1)), 0, 1'($urandom_range(1)));  // R11 back-to-back sweeps
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    tests++;
    fails++;
    $display("FAIL R9 watchdog: cycle %0d expected below %0d", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule